// File: doc/BRIEF.md
# Completion-Flag Handshake Pipeline Controller

This block sequences a chain of pipeline stages whose logic takes a variable number of cycles, in the manner of a self-timed pipeline modelled on one clock. Each stage owns a single completion flag. Upstream, the flag acts as an acknowledge. Downstream, the same flag acts as a request. A stage opens its data latch when the stage before it raises its flag and the stage itself is empty. It then waits for its dual-rail logic outputs to leave their equal reset state and become complementary. When that happens, the stage raises its own flag and emits a one-cycle reset pulse that clears the flag of the stage before it.

The word source drives a level request with a data word. The first stage's reset pulse is returned to the source as the acknowledge that retires that word. The last stage's flag is the output request. The consumer answers it with a one-cycle acknowledge. The per-stage rail pairs come from the logic being controlled. Only their relationship to each other (equal or complementary) matters to the controller.

Top module: `cspipe_chain`

## Requirements
- R1: After reset, no stage holds or works on an item: `lat_en`, `in_ack` and `out_req` are all 0 as long as `in_req` is 0.
- R2: Bit i of `lat_en` is 1 in a cycle where stage i is empty and its upstream flag is 1 (for stage 0 the upstream flag is `in_req`; for stage i>0 it is stage i-1's completion flag). The upstream word is captured at the end of that cycle, and the stage counts as working from the next cycle.
- R3: A working stage completes in the first cycle in which every one of its PAIRS rail pairs is complementary (`rail_t[k] != rail_f[k]`, where stage i owns pairs i*PAIRS to i*PAIRS+PAIRS-1). Its completion flag is 1 from the next cycle. Rail values have no effect on a stage that is not working.
- R4: In the completion cycle the stage asserts its reset pulse for exactly that cycle, and the upstream completion flag is 0 from the next cycle. For stage 0 this pulse is `in_ack`, which retires the word on `in_data`. The source then presents the next word or lowers `in_req`.
- R5: A stage whose flag is set keeps its flag and its word unchanged until the next stage completes. For the last stage, that event is a cycle with `out_ack` high. The stage is empty from the following cycle. `out_req` is the last stage's flag, and `out_data` is its word.
- R6: `out_ack` in a cycle where `out_req` is 0 is ignored.
- R7: A slow stage stalls the stages ahead of it without losing or repeating any word.
- R8: A pause in the input does not stop words already accepted from reaching the output.
- R9: Words leave on `out_data` in acceptance order, unchanged, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Source request level (upstream flag of stage 0) |
| in_data | input | DW | Source word |
| in_ack | output | 1 | Stage 0 reset pulse; retires the presented word |
| rail_t | input | STAGES*PAIRS | True rails of every stage's dual-rail outputs |
| rail_f | input | STAGES*PAIRS | False rails of every stage's dual-rail outputs |
| lat_en | output | STAGES | Per-stage data latch enable |
| out_req | output | 1 | Last stage completion flag |
| out_data | output | DW | Last stage word |
| out_ack | input | 1 | Consumer acknowledge pulse |

## Verification
The bench builds the chain with STAGES=4, DW=16 and PAIRS=2. Four stages give interior stages that both receive and send reset pulses. Two rail pairs per stage let each pair finish at its own delay, which exercises completion across more than one fan-in. The bench's behavioural model drives per-pair latencies of 1 to 8 cycles and a fixed slow third stage. It also adds input gaps, a consumer that is sometimes slow, and stray acknowledges while the output is empty, and it compares every latch enable and both handshake outputs on each clock.

// File: rtl/cspipe_pkg.sv
package cspipe_pkg;
  // Occupancy of one stage: empty, logic running, result held (flag up)
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_FULL  = 2'd2
  } slot_e;
endpackage

// File: rtl/cspipe_cmpl.sv
module cspipe_cmpl #(
  parameter int PAIRS = 2
) (
  input  logic [PAIRS-1:0] rail_t,
  input  logic [PAIRS-1:0] rail_f,
  output logic             settled
);
  // Every fan-in pair must have split to complementary values
  function automatic logic all_split(input logic [PAIRS-1:0] t, input logic [PAIRS-1:0] f);
    logic r;
    r = 1'b1;
    for (int k = 0; k < PAIRS; k++) r = r & (t[k] ^ f[k]);
    return r;
  endfunction

  assign settled = all_split(rail_t, rail_f);
endmodule

// File: rtl/cspipe_stage.sv
module cspipe_stage
  import cspipe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_gc,
  input  logic [DW-1:0]    up_data,
  input  logic             dn_phi,
  input  logic [PAIRS-1:0] rail_t,
  input  logic [PAIRS-1:0] rail_f,
  output logic             lat_en,
  output logic             phi,
  output logic             gc,
  output logic [DW-1:0]    word_q
);
  slot_e slot_q, slot_d;
  logic  settled;
  logic  busy;
  logic  release_ev;

  cspipe_cmpl #(.PAIRS(PAIRS)) u_cmpl (
    .rail_t (rail_t),
    .rail_f (rail_f),
    .settled(settled)
  );

  assign busy       = (slot_q == SLOT_BUSY);
  assign gc         = (slot_q == SLOT_FULL);
  assign lat_en     = up_gc && (slot_q == SLOT_EMPTY);
  assign phi        = busy && settled;
  assign release_ev = gc && dn_phi;

  always_comb begin
    slot_d = slot_q;
    unique case (slot_q)
      SLOT_EMPTY: if (lat_en)  slot_d = SLOT_BUSY;
      SLOT_BUSY:  if (settled) slot_d = SLOT_FULL;
      SLOT_FULL:  if (dn_phi)  slot_d = SLOT_EMPTY;
      default:                 slot_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_EMPTY;
      word_q <= '0;
    end else begin
      slot_q <= slot_d;
      if (lat_en) word_q <= up_data;
    end
  end

  // R2
  capture_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> busy && (word_q == $past(up_data)));

  // R2
  no_double_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> !lat_en);

  // R3
  complete_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi |=> gc);

  // R3
  flag_from_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc) |-> $past(busy));

  // R5
  hold_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc && !dn_phi |=> gc && $stable(word_q));

  // R5
  release_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !gc && !busy);
endmodule

// File: rtl/cspipe_chain.sv
module cspipe_chain #(
  parameter int STAGES = 4,
  parameter int DW     = 16,
  parameter int PAIRS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_req,
  input  logic [DW-1:0]           in_data,
  output logic                    in_ack,
  input  logic [STAGES*PAIRS-1:0] rail_t,
  input  logic [STAGES*PAIRS-1:0] rail_f,
  output logic [STAGES-1:0]       lat_en,
  output logic                    out_req,
  output logic [DW-1:0]           out_data,
  input  logic                    out_ack
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] gc;
  logic [STAGES-1:0] phi;
  logic [STAGES-1:0] up_gc;
  logic [STAGES-1:0] dn_phi;
  logic [DW-1:0]     up_word [STAGES];
  logic [DW-1:0]     word    [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign up_gc[i]   = in_req;
      assign up_word[i] = in_data;
    end else begin : g_body
      assign up_gc[i]   = gc[i-1];
      assign up_word[i] = word[i-1];
    end
    if (i == LAST) begin : g_tail
      assign dn_phi[i] = out_ack;
    end else begin : g_mid
      assign dn_phi[i] = phi[i+1];
    end

    cspipe_stage #(.DW(DW), .PAIRS(PAIRS)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_gc  (up_gc[i]),
      .up_data(up_word[i]),
      .dn_phi (dn_phi[i]),
      .rail_t (rail_t[i*PAIRS +: PAIRS]),
      .rail_f (rail_f[i*PAIRS +: PAIRS]),
      .lat_en (lat_en[i]),
      .phi    (phi[i]),
      .gc     (gc[i]),
      .word_q (word[i])
    );

    if (i > 0) begin : g_clr_chk
      // R4
      upstream_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phi[i] |=> !gc[i-1]);
    end
  end

  assign in_ack   = phi[0];
  assign out_req  = gc[LAST];
  assign out_data = word[LAST];

  // R6
  stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ack && !out_req && !phi[LAST] |=> !out_req);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req && $stable(out_data));
endmodule

// File: tb/cspipe_chain_bench.sv
module cspipe_chain_bench;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int P  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           in_req;
  logic [DW-1:0]  in_data;
  logic           in_ack;
  logic [N*P-1:0] ra, rb;
  logic [N-1:0]   lat_en;
  logic           out_req;
  logic [DW-1:0]  out_data;
  logic           out_ack;

  cspipe_chain #(.STAGES(N), .DW(DW), .PAIRS(P)) u_cspipe_chain (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .rail_t(ra), .rail_f(rb), .lat_en(lat_en), .out_req(out_req),
    .out_data(out_data), .out_ack(out_ack)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit timeout = 0;

  // model state: 0 empty, 1 working, 2 holding
  int            st [N];
  logic [DW-1:0] rd [N];
  int            left [N][P];
  bit            reseed [N];
  int            lat_max [N];
  int            lat_fix [N];
  logic [DW-1:0] sent_q [$];
  int to_send = 0, presented = 0, got = 0, seq = 0;
  int mode = 0, ack_div = 1;
  bit stray = 0;
  logic          req_plan = 0, ack_plan = 0;
  logic [DW-1:0] data_plan = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_word();
    logic [DW-1:0] w;
    w = DW'(seq) ^ 16'hA5C3;
    seq++;
    return w;
  endfunction

  task automatic step();
    bit en [N];
    bit dn [N];
    int nst [N];
    logic [DW-1:0] nrd [N];
    bit all;
    bit up;
    bit rel;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (reseed[i]) begin
        for (int j = 0; j < P; j++) begin
          bit e;
          e = 1'($urandom % 2);
          ra[i*P+j] = e;
          rb[i*P+j] = e;
          left[i][j] = (lat_fix[i] > 0) ? lat_fix[i] : 1 + int'($urandom % lat_max[i]);
        end
        reseed[i] = 0;
      end else begin
        for (int j = 0; j < P; j++)
          if (left[i][j] > 0) begin
            left[i][j]--;
            if (left[i][j] == 0) rb[i*P+j] = ~ra[i*P+j];
          end
      end
    end
    in_req = req_plan; in_data = data_plan; out_ack = ack_plan;
    #1;
    for (int i = 0; i < N; i++) begin
      all = 1;
      for (int j = 0; j < P; j++) if (ra[i*P+j] == rb[i*P+j]) all = 0;
      dn[i] = (st[i] == 1) && all;
      up = (i == 0) ? in_req : (st[i-1] == 2);
      en[i] = up && (st[i] == 0);
      // R2 R3: capture follows upstream flag; downstream capture reveals completion
      chk(lat_en[i] == en[i], $sformatf("R2 R3 lat_en[%0d]", i), lat_en[i], en[i]);
    end
    // R4
    chk(in_ack == dn[0], "R3 R4 in_ack", in_ack, dn[0]);
    // R5 R6
    chk(out_req == (st[N-1] == 2), (out_ack && st[N-1] != 2) ? "R6 out_req" : "R5 out_req",
        out_req, st[N-1] == 2);
    if (st[N-1] == 2) chk(out_data == rd[N-1], "R5 out_data", out_data, rd[N-1]);
    if (en[0]) sent_q.push_back(in_data);
    if (st[N-1] == 2 && out_ack) begin
      logic [DW-1:0] e;
      e = (sent_q.size() > 0) ? sent_q.pop_front() : '1;
      // R9
      chk(out_data == e, "R9 order", out_data, e);
      got++;
    end
    for (int i = 0; i < N; i++) begin
      nst[i] = st[i]; nrd[i] = rd[i];
      rel = (i < N-1) ? dn[i+1] : out_ack;
      if (st[i] == 0 && en[i]) begin
        nst[i] = 1;
        nrd[i] = (i == 0) ? in_data : rd[i-1];
      end else if (st[i] == 1 && dn[i]) nst[i] = 2;
      else if (st[i] == 2 && rel) nst[i] = 0;
      reseed[i] = en[i];
    end
    for (int i = 0; i < N; i++) begin st[i] = nst[i]; rd[i] = nrd[i]; end
    // source plan
    if (in_req && dn[0]) begin
      if (to_send > 0 && !(mode == 1 && $urandom % 3 == 0)) begin
        data_plan = next_word(); to_send--; presented++; req_plan = 1;
      end else req_plan = 0;
    end else if (!in_req && to_send > 0 && (mode != 1 || $urandom % 4 == 0)) begin
      data_plan = next_word(); to_send--; presented++; req_plan = 1;
    end
    // consumer plan
    if (out_ack) ack_plan = 0;
    else if (out_req) ack_plan = ($urandom % ack_div == 0);
    else ack_plan = stray && ($urandom % 6 == 0);
    cycles++;
    if (cycles > 190000 && !timeout) begin
      timeout = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    end
  endtask

  task automatic run_items(input int n);
    to_send = n;
    while (!timeout && (to_send > 0 || got < presented)) step();
  endtask

  initial begin
    rst_n = 0; in_req = 0; in_data = '0; out_ack = 0; ra = '0; rb = '0;
    for (int i = 0; i < N; i++) begin
      st[i] = 0; rd[i] = '0; reseed[i] = 0; lat_max[i] = 8; lat_fix[i] = 0;
      for (int j = 0; j < P; j++) left[i][j] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(lat_en == '0, "R1 lat_en", lat_en, 0);
    chk(in_ack == 0, "R1 in_ack", in_ack, 0);
    chk(out_req == 0, "R1 out_req", out_req, 0);

    // random latencies, steady source
    mode = 0; ack_div = 2;
    run_items(60);
    chk(got == presented, "R9 count", got, presented);

    // slow third stage stalls the others
    for (int i = 0; i < N; i++) lat_fix[i] = 1;
    lat_fix[2] = 8; ack_div = 1;
    run_items(40);
    // R7
    chk(got == presented && sent_q.size() == 0, "R7 stall lossless", got, presented);

    // input gaps, slow consumer, stray acknowledges
    for (int i = 0; i < N; i++) begin lat_fix[i] = 0; lat_max[i] = 4; end
    mode = 1; ack_div = 3; stray = 1;
    run_items(40);
    chk(got == presented, "R9 gaps count", got, presented);

    // short burst then silence: the burst must drain
    mode = 0;
    to_send = 3;
    repeat (120) if (!timeout) step();
    // R8
    chk(got == presented && to_send == 0, "R8 drain", got, presented);
    repeat (40) if (!timeout) step();
    // R6
    chk(out_req == 0, "R6 idle out_req", out_req, 0);
    chk(sent_q.size() == 0, "R9 no leftovers", sent_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule